// File: doc/BRIEF.md
# Splittable Performance Counter Unit

The block counts hardware events in four physical counters behind a small register interface. Each physical counter runs either as one 32-bit counter or as two independent 16-bit halves. That gives up to eight logical counters, and each logical counter has its own event pulse input. A single control register starts and stops all counting and picks the width mode of each physical counter. Each logical counter sets its own overflow bit when it wraps. Overflow bits raise an interrupt when they are enabled by a mask. Reading the status register returns the pending bits and clears them in the same access.

Software never writes a running counter directly. A write to a counter register goes into a holding latch belonging to its physical counter. The live counter takes the latched value only when the control register is written with its run bit set, and this includes a rewrite while the unit is already running. Registers are 32 bits wide. On the 64-bit bus they occupy the upper lane: the write port carries only that lane, and the read port returns zeros in bits 31:0.

Top module: `perfmon_split_counter`

## Requirements
- R1: After reset, every counter, the control register, the status bits and the interrupt mask are zero, and `irq_o` is low.
- R2: While the run bit (control bit 0) is 1, a counter advances by one at each clock edge where its event input is high. While the run bit is 0, no counter changes except by a commit.
- R3: With its split bit clear, physical counter p (control bit p+1) counts `evt_i[p]` as one 32-bit value and ignores `evt_i[p+4]`. It wraps from FFFFFFFF to 0 and sets status bit p on that wrap.
- R4: With its split bit set, physical counter p has two halves. The upper 16 bits are logical counter p and count `evt_i[p]`. The lower 16 bits are logical counter p+4 and count `evt_i[p+4]`. Each half wraps from FFFF to 0 with no carry into the other half and sets status bit p or p+4.
- R5: A write to a counter register (address 2+i for logical i) changes only the holding latch of its physical counter. Every pending latch is copied into its live counter when the control register (address 0) is written with bit 0 set. A read of a counter whose latch is pending returns the latch contents.
- R6: While physical counter p is in 32-bit mode, writes to logical counter p+4 are ignored and reads of it return 0.
- R7: A read of the status register (address 1) returns the pending overflow bits, one per logical counter, and clears them. An overflow in the same cycle as the read stays set.
- R8: A write to the status register loads the interrupt mask. `irq_o` is high exactly when some status bit is set together with its mask bit, so a zero mask keeps it low.
- R9: Register data travels in bits 63:32 of the bus word, and bits 31:0 of `bus_rdata` are always 0. A read with `bus_rd` low returns 0.
- R10: A 16-bit counter write replaces only its own half. The other half of the latch is taken from the pending latch if there is one, otherwise from the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 4 | Register index: 0 control, 1 status/mask, 2..9 logical counters 0..7 |
| bus_wdata | input | 32 | Write data, upper lane (bits 63:32) of the bus word |
| bus_rdata | output | 64 | Read data, combinational, register value in bits 63:32 |
| evt_i | input | 8 | Event pulse per logical counter |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
A wrong latch or pending flag stays hidden until the next enabling control write. After that, the counter readback is off by exactly the number of events counted since the latch write. A carry leaking between split halves, or a missed wrap, appears at the counter readback and as a missing status bit one cycle after the wrapping event. A wrong clear priority loses an overflow that lands on the same edge as a status read. That loss shows on the following status read and on `irq_o` one cycle later.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned BUS_W    = 64;
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_STAT = 1;
    localparam int unsigned ADR_CNT0 = 2;
endpackage

// File: rtl/pmu_phys_ctr.sv
// One physical counter: a single full-width counter, or two halves with no carry between them.
module pmu_phys_ctr #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          split,
    input  logic          evt_hi,
    input  logic          evt_lo,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_hi,
    output logic          ovf_lo
);
    localparam int unsigned HW = CW / 2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        ovf_hi = 1'b0;
        ovf_lo = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (run) begin
            if (split) begin
                if (evt_hi) begin
                    cnt_d[CW-1:HW] = cnt_q[CW-1:HW] + 1'b1;
                    ovf_hi         = &cnt_q[CW-1:HW];
                end
                if (evt_lo) begin
                    cnt_d[HW-1:0] = cnt_q[HW-1:0] + 1'b1;
                    ovf_lo        = &cnt_q[HW-1:0];
                end
            end else if (evt_hi) begin
                cnt_d  = cnt_q + 1'b1;
                ovf_hi = &cnt_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_rd_mux.sv
// Read data selection; a pending latch hides the live counter value.
module pmu_rd_mux #(
    parameter int unsigned NPHYS = 4,
    parameter int unsigned CW    = 32,
    parameter int unsigned AW    = 4
) (
    input  logic                       rd,
    input  logic [AW-1:0]              addr,
    input  logic                       run,
    input  logic [NPHYS-1:0]           split,
    input  logic [2*NPHYS-1:0]         status,
    input  logic [NPHYS-1:0]           pend,
    input  logic [NPHYS-1:0][CW-1:0]   latch,
    input  logic [NPHYS-1:0][CW-1:0]   cnt,
    output logic [pmu_pkg::BUS_W-1:0]  rdata
);
    import pmu_pkg::*;
    localparam int unsigned NLOG = 2 * NPHYS;
    localparam int unsigned HW   = CW / 2;
    localparam int unsigned PW   = $clog2(NPHYS);

    logic [REG_W-1:0] val;
    logic [AW-1:0]    idx;
    logic [PW-1:0]    pidx;
    logic             upper;
    logic [CW-1:0]    src;

    always_comb begin
        val   = '0;
        idx   = addr - AW'(ADR_CNT0);
        pidx  = idx[PW-1:0];
        upper = (idx < AW'(NPHYS));
        src   = pend[pidx] ? latch[pidx] : cnt[pidx];
        if (rd) begin
            if (addr == AW'(ADR_CTRL)) begin
                val[0]       = run;
                val[NPHYS:1] = split;
            end else if (addr == AW'(ADR_STAT)) begin
                val[NLOG-1:0] = status;
            end else if (addr < AW'(ADR_CNT0 + NLOG)) begin
                if (split[pidx])
                    val[HW-1:0] = upper ? src[CW-1:HW] : src[HW-1:0];
                else if (upper)
                    val[CW-1:0] = src;
            end
        end
        rdata = {val, {(BUS_W-REG_W){1'b0}}};
    end
endmodule

// File: rtl/perfmon_split_counter.sv
// NPHYS must be a power of two, and CW must not exceed the 32-bit register width.
module perfmon_split_counter #(
    parameter int unsigned NPHYS = 4,
    parameter int unsigned CW    = 32,
    parameter int unsigned AW    = $clog2(2*NPHYS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    input  logic [2*NPHYS-1:0] evt_i,
    output logic              irq_o
);
    import pmu_pkg::*;
    localparam int unsigned NLOG = 2 * NPHYS;
    localparam int unsigned HW   = CW / 2;
    localparam int unsigned PW   = $clog2(NPHYS);

    typedef struct packed {
        logic                     run;
        logic [NPHYS-1:0]         split;
        logic [NLOG-1:0]          mask;
        logic [NLOG-1:0]          status;
        logic [NPHYS-1:0]         pend;
        logic [NPHYS-1:0][CW-1:0] latch;
    } pmu_state_t;

    pmu_state_t               st_d, st_q;
    logic [NPHYS-1:0]         load_w;
    logic [NPHYS-1:0][CW-1:0] cnt_w;
    logic [NPHYS-1:0][CW-1:0] latch_w;
    logic [NLOG-1:0]          ovf_w;
    logic [NLOG-1:0]          status_w;
    logic [NPHYS-1:0]         pend_w;
    logic                     run_w;
    logic                     stat_rd;
    logic [AW-1:0]            widx;
    logic [PW-1:0]            wp;
    logic                     wupper;
    logic [CW-1:0]            wbase;

    assign stat_rd  = bus_rd && (bus_addr == AW'(ADR_STAT));
    assign latch_w  = st_q.latch;
    assign status_w = st_q.status;
    assign pend_w   = st_q.pend;
    assign run_w    = st_q.run;

    always_comb begin
        st_d   = st_q;
        load_w = '0;
        widx   = bus_addr - AW'(ADR_CNT0);
        wp     = widx[PW-1:0];
        wupper = (widx < AW'(NPHYS));
        wbase  = st_q.pend[wp] ? st_q.latch[wp] : cnt_w[wp];
        if (bus_wr) begin
            if (bus_addr == AW'(ADR_CTRL)) begin
                st_d.run   = bus_wdata[0];
                st_d.split = bus_wdata[NPHYS:1];
                if (bus_wdata[0]) begin
                    load_w    = st_q.pend;
                    st_d.pend = '0;
                end
            end else if (bus_addr == AW'(ADR_STAT)) begin
                st_d.mask = bus_wdata[NLOG-1:0];
            end else if (bus_addr < AW'(ADR_CNT0 + NLOG)) begin
                if (st_q.split[wp]) begin
                    if (wupper) wbase[CW-1:HW] = bus_wdata[HW-1:0];
                    else        wbase[HW-1:0]  = bus_wdata[HW-1:0];
                    st_d.latch[wp] = wbase;
                    st_d.pend[wp]  = 1'b1;
                end else if (wupper) begin
                    st_d.latch[wp] = bus_wdata[CW-1:0];
                    st_d.pend[wp]  = 1'b1;
                end
            end
        end
        // a new overflow outranks the clear-on-read
        st_d.status = (stat_rd ? '0 : st_q.status) | ovf_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPHYS; p++) begin : g_ctr
        pmu_phys_ctr #(.CW(CW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (st_q.run),
            .split    (st_q.split[p]),
            .evt_hi   (evt_i[p]),
            .evt_lo   (evt_i[p+NPHYS]),
            .load     (load_w[p]),
            .load_val (st_q.latch[p]),
            .cnt_o    (cnt_w[p]),
            .ovf_hi   (ovf_w[p]),
            .ovf_lo   (ovf_w[p+NPHYS])
        );
    end

    pmu_rd_mux #(.NPHYS(NPHYS), .CW(CW), .AW(AW)) u_rd (
        .rd     (bus_rd),
        .addr   (bus_addr),
        .run    (st_q.run),
        .split  (st_q.split),
        .status (st_q.status),
        .pend   (st_q.pend),
        .latch  (st_q.latch),
        .cnt    (cnt_w),
        .rdata  (bus_rdata)
    );

    assign irq_o = |(st_q.status & st_q.mask);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int unsigned NPHYS = 4,
    parameter int unsigned CW    = 32,
    parameter int unsigned AW    = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     run,
    input logic                     bus_rd,
    input logic [AW-1:0]            bus_addr,
    input logic [NPHYS-1:0]         load,
    input logic [NPHYS-1:0][CW-1:0] latch,
    input logic [NPHYS-1:0][CW-1:0] cnt,
    input logic [2*NPHYS-1:0]       status,
    input logic [2*NPHYS-1:0]       ovf
);
    localparam int unsigned HW   = CW / 2;
    localparam int unsigned NLOG = 2 * NPHYS;

    logic stat_rd;
    assign stat_rd = bus_rd && (bus_addr == AW'(1));

    for (genvar p = 0; p < NPHYS; p++) begin : g_p
        AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !load[p]) |=> $stable(cnt[p])); // R2
        AST_STEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !load[p]) |=> (HW'(cnt[p][CW-1:HW] - $past(cnt[p][CW-1:HW])) <= HW'(1))); // R2
        AST_STEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !load[p]) |=> (HW'(cnt[p][HW-1:0] - $past(cnt[p][HW-1:0])) <= HW'(1))); // R4
        AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            load[p] |=> (cnt[p] == $past(latch[p]))); // R5
    end

    for (genvar i = 0; i < NLOG; i++) begin : g_l
        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !stat_rd) |=> status[i]); // R7
        AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> status[i]); // R7
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (ovf == '0)) |=> (status == '0)); // R7
endmodule

bind perfmon_split_counter pmu_checker #(.NPHYS(NPHYS), .CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .load     (load_w),
    .latch    (latch_w),
    .cnt      (cnt_w),
    .status   (status_w),
    .ovf      (ovf_w)
);

// File: tb/perfmon_split_counter_tb.sv
`timescale 1ns/1ps
module perfmon_split_counter_tb;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [7:0]  evt_i = '0;
    logic        irq_o;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    perfmon_split_counter u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        #1;
        v = bus_rdata[63:32];
        nchk++;
        if (bus_rdata[31:0] !== 32'h0) begin
            nerr++;
            $display("FAIL R9 actual=%h expected=0", bus_rdata[31:0]);
        end
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        @(negedge clk);
        evt_i = m;
        repeat (n) @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #500000;
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 status", v, 0);
        for (int i = 0; i < 8; i++) begin rd(2 + i, v); chk("R1 counter", v, 0); end
        chk("R1 irq", {31'h0, irq_o}, 0);
        // R2 R3 32-bit counting
        wr(0, 32'h1);
        pulse(8'hFF, 5);
        wr(0, 32'h0);
        for (int i = 0; i < 4; i++) begin rd(2 + i, v); chk("R3 count", v, 5); end
        for (int i = 4; i < 8; i++) begin rd(2 + i, v); chk("R6 read 0", v, 0); end
        pulse(8'hFF, 3);
        rd(2, v); chk("R2 stopped", v, 5);
        // R5 latch and commit
        wr(2, 32'hFFFF_FFFD);
        rd(2, v); chk("R5 latch read", v, 32'hFFFF_FFFD);
        rd(3, v); chk("R5 other live", v, 5);
        wr(0, 32'h1);
        pulse(8'h01, 3);
        rd(2, v); chk("R3 wrap", v, 0);
        rd(1, v); chk("R3 status", v, 32'h01);
        rd(1, v); chk("R7 cleared", v, 0);
        wr(3, 32'd100);
        pulse(8'h02, 2);
        wr(0, 32'h1);
        pulse(8'h02, 1);
        rd(3, v); chk("R5 rewrite commit", v, 101);
        wr(0, 32'h0);
        // R4 R10 split halves on physical 2
        wr(0, 32'h8);
        wr(4, 32'h0000_FFFE);
        wr(8, 32'h0000_FFFF);
        rd(4, v); chk("R10 upper", v, 32'hFFFE);
        rd(8, v); chk("R10 lower", v, 32'hFFFF);
        wr(1, 32'h40);
        wr(0, 32'h9);
        chk("R8 irq idle", {31'h0, irq_o}, 0);
        pulse(8'h44, 1);
        rd(4, v); chk("R4 no carry", v, 32'hFFFF);
        rd(8, v); chk("R4 lower wrap", v, 0);
        chk("R8 irq set", {31'h0, irq_o}, 1);
        rd(1, v); chk("R4 status lo", v, 32'h40);
        chk("R8 irq cleared", {31'h0, irq_o}, 0);
        pulse(8'h04, 1);
        chk("R8 masked", {31'h0, irq_o}, 0);
        rd(1, v); chk("R4 status hi", v, 32'h04);
        // R7 overflow beats same-cycle clear
        wr(8, 32'hFFFF);
        wr(0, 32'h9);
        @(negedge clk);
        evt_i = 8'h40; bus_rd = 1'b1; bus_addr = 4'd1;
        #1 chk("R7 read before", bus_rdata[63:32], 0);
        @(negedge clk);
        evt_i = '0; bus_rd = 1'b0;
        rd(1, v); chk("R7 kept", v, 32'h40);
        // R8 zero mask
        wr(8, 32'hFFFF);
        wr(1, 32'h0);
        wr(0, 32'h9);
        pulse(8'h40, 1);
        chk("R8 zero mask", {31'h0, irq_o}, 0);
        rd(1, v); chk("R8 status", v, 32'h40);
        wr(0, 32'h0);
        // sweep over physical counters and both modes
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                logic [31:0] cfg;
                cfg = 32'(s) << (p + 1);
                wr(0, cfg);
                if (s == 0) begin
                    wr(2 + p + 4, 32'h1234);
                    wr(2 + p, 32'hFFFF_FFFF - 32'(p));
                end else begin
                    wr(2 + p, 32'hFFFF - 32'(p));
                    wr(2 + p + 4, 32'h1000 * 32'(p) + 7);
                end
                wr(0, cfg | 32'h1);
                pulse(8'(1 << p), p + 2);
                pulse(8'(1 << (p + 4)), 3);
                wr(0, cfg);
                rd(2 + p, v); chk(s ? "R4 sweep hi" : "R3 sweep", v, 1);
                rd(2 + p + 4, v);
                chk(s ? "R4 sweep lo" : "R6 sweep", v, s ? 32'h1000 * 32'(p) + 10 : 0);
                rd(1, v); chk("R7 sweep status", v, 32'(1) << p);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule